// File: doc/BRIEF.md
# Dual-Source Spaced-Tap Random Bit Generator

This block produces pseudo-random bits by running two independent sequence generators on one clock and mixing them. One is a 37-bit shift register with external XOR feedback. The other is a 16-cell one-dimensional cellular automaton in which each cell follows its own rule: either rule 90 or rule 150. Both advance together on every enabled cycle. Each output bit is the XOR of one shift-register bit and one automaton bit. The pairs of sites are spread evenly along both registers, so neighbouring output bits are never drawn from neighbouring storage bits.

When the cycle lengths of the two generators share no common factor, the mixed stream repeats only after the product of the two lengths. The `OUT_W` parameter sets the output width to 1, 2 or 4 bits per cycle. A wider output raises throughput, but the sites then sit closer together.

A synchronous load writes separate seeds into the two generators. An all-zero seed would lock its generator at zero forever, so it is replaced by a fixed nonzero default. Each cycle the block acts on one command, decoded from its inputs in priority order:

- **LOAD**: `load_i` is high. Both generators take their seeds.
- **STEP**: `load_i` is low and `enable_i` is high. Both generators advance.
- **HOLD**: neither input is high. Both generators keep their state.

Top module: `lfsr_ca_rng`

## Requirements
- R1: While `rst` is sampled high at a clock edge, the shift register is set to `LFSR_DEF` (default 1) and the automaton to `CA_DEF` (default 1). These values are visible on `rnd_o` in the cycle after `rst` falls.
- R2: `load_i` takes priority over `enable_i`. In the cycle after a load edge, both registers hold the supplied seeds.
- R3: A load with an all-zero shift-register seed sets the shift register to `LFSR_DEF` instead.
- R4: A load with an all-zero automaton seed sets the automaton to `CA_DEF` instead.
- R5: On a step, the shift register moves one position toward bit 36. Bit 0 takes the XOR of bits 36, 4, 3, 2, 1 and 0 from before the step.
- R6: On a step, automaton cell i takes the XOR of cell i-1 and cell i+1. Cells outside the array count as 0. When bit i of `CA_RULES` is 1, the XOR also includes the cell's own old value (rule 150); when the bit is 0, it does not (rule 90).
- R7: With `load_i` and `enable_i` both low, both registers hold, so `rnd_o` does not change.
- R8: With `OUT_W`=1, `rnd_o[0]` is the XOR of shift-register bit 36 and automaton cell 15.
- R9: With `OUT_W`=2, `rnd_o[0]` is the XOR of bit 36 and cell 15, and `rnd_o[1]` is the XOR of bit 18 and cell 7.
- R10: With `OUT_W`=4, output bit k (k = 0 to 3) is the XOR of shift-register bit 36-9k and automaton cell 15-4k.
- R11: Both generators advance exactly once on every STEP cycle. No rate difference exists between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Load both seeds (LOAD command) |
| enable_i | input | 1 | Advance both generators (STEP command) |
| lfsr_seed_i | input | LFSR_W | Shift-register seed |
| ca_seed_i | input | CA_W | Automaton seed |
| rnd_o | output | OUT_W | Mixed random bits |

## Verification
A walking sequence from the default state exposes the feedback tap set and the per-cell rule assignment, because any wrong tap or rule makes the stream diverge within a few steps. Dense seeds (all ones, alternating bits) exercise both null boundaries and both rule types at once. Zero seeds applied to one side at a time show that each default substitution acts on its own generator only.

The three output widths run side by side on the same stimulus, which separates the site positions of each mode. Bursts of HOLD cycles, and loads asserted together with enable, separate the priority of the commands from the stepping itself.

// File: rtl/lcr_pkg.sv
package lcr_pkg;

    typedef enum logic [1:0] {
        CMD_HOLD = 2'd0,
        CMD_STEP = 2'd1,
        CMD_LOAD = 2'd2
    } lcr_cmd_e;

    function automatic lcr_cmd_e lcr_decode(input logic load, input logic enable);
        if (load)
            return CMD_LOAD;
        else if (enable)
            return CMD_STEP;
        else
            return CMD_HOLD;
    endfunction

endpackage

// File: rtl/lcr_shift_gen.sv
module lcr_shift_gen
    import lcr_pkg::*;
#(
    parameter int          W    = 37,
    parameter logic [W-1:0] TAPS = 37'h10_0000_001F,
    parameter logic [W-1:0] DEF  = 37'h1
) (
    input  logic         clk,
    input  logic         rst,
    input  lcr_cmd_e     cmd,
    input  logic [W-1:0] seed,
    output logic [W-1:0] state
);
    localparam logic [W-1:0] ZERO = '0;

    logic         fb;
    logic [W-1:0] nxt;

    always_comb begin
        fb  = ^(state & TAPS);
        nxt = {state[W-2:0], fb};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= DEF;
        end else begin
            unique case (cmd)
                CMD_LOAD: state <= (seed == ZERO) ? DEF : seed;
                CMD_STEP: state <= nxt;
                CMD_HOLD: state <= state;
                default:  state <= state;
            endcase
        end
    end

    // R5: a step shifts toward the top bit
    a_r5_shift_up: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_STEP) |=> (state[W-1:1] == $past(state[W-2:0])));

    // R3: zero seed replaced by the default
    a_r3_zero_seed: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_LOAD && seed == ZERO) |=> (state == DEF));

    // R7: hold keeps the state
    a_r7_shift_hold: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_HOLD) |=> $stable(state));

endmodule

// File: rtl/lcr_cell_array.sv
module lcr_cell_array
    import lcr_pkg::*;
#(
    parameter int           W     = 16,
    parameter logic [W-1:0] RULES = 16'h4D2B,
    parameter logic [W-1:0] DEF   = 16'h0001
) (
    input  logic         clk,
    input  logic         rst,
    input  lcr_cmd_e     cmd,
    input  logic [W-1:0] seed,
    output logic [W-1:0] state
);
    localparam logic [W-1:0] ZERO = '0;

    logic [W-1:0] nxt;

    for (genvar i = 0; i < W; i++) begin : g_cell
        logic lft, rgt;
        if (i == 0) begin : g_lo
            assign lft = 1'b0;
        end else begin : g_lo_n
            assign lft = state[i-1];
        end
        if (i == W-1) begin : g_hi
            assign rgt = 1'b0;
        end else begin : g_hi_n
            assign rgt = state[i+1];
        end
        if (RULES[i]) begin : g_r150
            assign nxt[i] = lft ^ state[i] ^ rgt;
        end else begin : g_r90
            assign nxt[i] = lft ^ rgt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= DEF;
        end else begin
            unique case (cmd)
                CMD_LOAD: state <= (seed == ZERO) ? DEF : seed;
                CMD_STEP: state <= nxt;
                CMD_HOLD: state <= state;
                default:  state <= state;
            endcase
        end
    end

    // R4: zero seed replaced by the default
    a_r4_zero_seed: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_LOAD && seed == ZERO) |=> (state == DEF));

    // R2: nonzero seed taken as given
    a_r2_ca_seed: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_LOAD && seed != ZERO) |=> (state == $past(seed)));

    // R7: hold keeps the state
    a_r7_cell_hold: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_HOLD) |=> $stable(state));

endmodule

// File: rtl/lcr_site_mix.sv
module lcr_site_mix #(
    parameter int LW    = 37,
    parameter int CW    = 16,
    parameter int OUT_W = 4
) (
    input  logic [LW-1:0]    lfsr_q,
    input  logic [CW-1:0]    ca_q,
    output logic [OUT_W-1:0] bits
);
    localparam int LSTEP = LW / OUT_W;
    localparam int CSTEP = CW / OUT_W;

    for (genvar k = 0; k < OUT_W; k++) begin : g_site
        localparam int LPOS = LW - 1 - k * LSTEP;
        localparam int CPOS = CW - 1 - k * CSTEP;
        assign bits[k] = lfsr_q[LPOS] ^ ca_q[CPOS];
    end

endmodule

// File: rtl/lfsr_ca_rng.sv
module lfsr_ca_rng
    import lcr_pkg::*;
#(
    parameter int                LFSR_W    = 37,
    parameter int                CA_W      = 16,
    parameter int                OUT_W     = 4,
    parameter logic [LFSR_W-1:0] LFSR_TAPS = 37'h10_0000_001F,
    parameter logic [LFSR_W-1:0] LFSR_DEF  = 37'h1,
    parameter logic [CA_W-1:0]   CA_RULES  = 16'h4D2B,
    parameter logic [CA_W-1:0]   CA_DEF    = 16'h0001
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic              enable_i,
    input  logic [LFSR_W-1:0] lfsr_seed_i,
    input  logic [CA_W-1:0]   ca_seed_i,
    output logic [OUT_W-1:0]  rnd_o
);
    lcr_cmd_e          cmd;
    logic [LFSR_W-1:0] lfsr_q;
    logic [CA_W-1:0]   ca_q;

    always_comb cmd = lcr_decode(load_i, enable_i);

    lcr_shift_gen #(.W(LFSR_W), .TAPS(LFSR_TAPS), .DEF(LFSR_DEF)) u_shift (
        .clk(clk), .rst(rst), .cmd(cmd), .seed(lfsr_seed_i), .state(lfsr_q)
    );

    lcr_cell_array #(.W(CA_W), .RULES(CA_RULES), .DEF(CA_DEF)) u_cells (
        .clk(clk), .rst(rst), .cmd(cmd), .seed(ca_seed_i), .state(ca_q)
    );

    lcr_site_mix #(.LW(LFSR_W), .CW(CA_W), .OUT_W(OUT_W)) u_mix (
        .lfsr_q(lfsr_q), .ca_q(ca_q), .bits(rnd_o)
    );

    // R2: a load with nonzero seeds shows the seed end bits on output bit 0
    a_r2_load_visible: assert property (@(posedge clk) disable iff (rst)
        (load_i && lfsr_seed_i != '0 && ca_seed_i != '0) |=>
        (rnd_o[0] == ($past(lfsr_seed_i[LFSR_W-1]) ^ $past(ca_seed_i[CA_W-1]))));

    // R7: no command leaves the output unchanged
    a_r7_out_hold: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !enable_i) |=> $stable(rnd_o));

endmodule

// File: tb/lfsr_ca_rng_bench.sv
module lfsr_ca_rng_bench;
    localparam int          CLK_PERIOD = 10;
    localparam int          LW = 37;
    localparam int          CW = 16;
    localparam logic [15:0] RULES = 16'h4D2B;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          load_i = 1'b0;
    logic          enable_i = 1'b0;
    logic [LW-1:0] lseed = '0;
    logic [CW-1:0] cseed = '0;
    logic [0:0]    out1;
    logic [1:0]    out2;
    logic [3:0]    u_out4;

    int  n_run = 0;
    int  n_fail = 0;
    bit  ended = 0;

    bit  ml [LW];
    bit  mc [CW];

    always #(CLK_PERIOD/2) clk = ~clk;

    lfsr_ca_rng #(.OUT_W(1), .CA_RULES(RULES)) u_lfsr_ca_rng_w1 (
        .clk(clk), .rst(rst), .load_i(load_i), .enable_i(enable_i),
        .lfsr_seed_i(lseed), .ca_seed_i(cseed), .rnd_o(out1));
    lfsr_ca_rng #(.OUT_W(2), .CA_RULES(RULES)) u_lfsr_ca_rng_w2 (
        .clk(clk), .rst(rst), .load_i(load_i), .enable_i(enable_i),
        .lfsr_seed_i(lseed), .ca_seed_i(cseed), .rnd_o(out2));
    lfsr_ca_rng #(.OUT_W(4), .CA_RULES(RULES)) u_lfsr_ca_rng (
        .clk(clk), .rst(rst), .load_i(load_i), .enable_i(enable_i),
        .lfsr_seed_i(lseed), .ca_seed_i(cseed), .rnd_o(u_out4));

    function automatic int expect_bits(int w);
        int r = 0;
        for (int k = 0; k < w; k++) begin
            int lp = 36 - k * (37 / w);
            int cp = 15 - k * (16 / w);
            r = r | (int'(ml[lp] ^ mc[cp]) << k);
        end
        return r;
    endfunction

    task automatic model_defaults();
        for (int i = 0; i < LW; i++) ml[i] = (i == 0);
        for (int i = 0; i < CW; i++) mc[i] = (i == 0);
    endtask

    task automatic model_step();
        bit nl [LW];
        bit nc [CW];
        int taps[$] = '{36, 4, 3, 2, 1, 0};
        bit fb = 0;
        foreach (taps[t]) fb ^= ml[taps[t]];
        nl[0] = fb;
        for (int i = 1; i < LW; i++) nl[i] = ml[i-1];
        for (int i = 0; i < CW; i++) begin
            bit l = (i > 0) ? mc[i-1] : 1'b0;
            bit r = (i < CW-1) ? mc[i+1] : 1'b0;
            nc[i] = l ^ r ^ (RULES[i] & mc[i]);
        end
        ml = nl;
        mc = nc;
    endtask

    task automatic model_load(logic [LW-1:0] ls, logic [CW-1:0] cs);
        if (ls == '0) for (int i = 0; i < LW; i++) ml[i] = (i == 0);
        else          for (int i = 0; i < LW; i++) ml[i] = ls[i];
        if (cs == '0) for (int i = 0; i < CW; i++) mc[i] = (i == 0);
        else          for (int i = 0; i < CW; i++) mc[i] = cs[i];
    endtask

    task automatic compare(string tag);
        int e1 = expect_bits(1);
        int e2 = expect_bits(2);
        int e4 = expect_bits(4);
        n_run += 3;
        if (int'(out1) != e1) begin
            n_fail++;
            $display("FAIL %s R8 width1 actual=%0h expected=%0h", tag, out1, e1);
        end
        if (int'(out2) != e2) begin
            n_fail++;
            $display("FAIL %s R9 width2 actual=%0h expected=%0h", tag, out2, e2);
        end
        if (int'(u_out4) != e4) begin
            n_fail++;
            $display("FAIL %s R10 width4 actual=%0h expected=%0h", tag, u_out4, e4);
        end
    endtask

    task automatic cycle(bit ld, bit en, logic [LW-1:0] ls, logic [CW-1:0] cs, string tag);
        load_i   = ld;
        enable_i = en;
        lseed    = ls;
        cseed    = cs;
        @(posedge clk);
        @(negedge clk);
        if (ld)      model_load(ls, cs);
        else if (en) model_step();
        compare(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!ended) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_defaults();
        compare("R1 reset state");

        // R5 R6 R11: walk from the defaults
        for (int n = 0; n < 40; n++) cycle(0, 1, '0, '0, "R5 R6 R11 walk");
        // R7: hold with seeds driven, no load
        for (int n = 0; n < 6; n++) cycle(0, 0, 37'h15_5555_5555, 16'hAAAA, "R7 hold");
        // R2: load together with enable
        cycle(1, 1, 37'h1F_FFFF_FFFF, 16'hFFFF, "R2 load priority");
        for (int n = 0; n < 30; n++) cycle(0, 1, '0, '0, "R6 dense walk");
        cycle(1, 0, 37'h0A_AAAA_AAAA, 16'h5555, "R2 alternating load");
        for (int n = 0; n < 30; n++) cycle(0, 1, '0, '0, "R5 alternating walk");
        // R3: zero shift-register seed
        cycle(1, 0, '0, 16'hC3A5, "R3 zero lfsr seed");
        for (int n = 0; n < 10; n++) cycle(0, 1, '0, '0, "R3 after");
        // R4: zero automaton seed
        cycle(1, 1, 37'h12_3456_789A, '0, "R4 zero ca seed");
        for (int n = 0; n < 10; n++) cycle(0, 1, '0, '0, "R4 after");
        // R11: mixed enable pattern over a long run
        for (int n = 0; n < 400; n++) cycle(0, (n % 3) != 1, '0, '0, "R11 gated run");
        for (int n = 0; n < 2000; n++) cycle(0, 1, '0, '0, "R11 long run");

        ended = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule